// File: doc/BRIEF.md
# Configurable Synchronous Serial Transmitter

This block is a clock-master serial output port. Parallel words arrive on a valid/ready handshake. Each word is shifted out on a single data line. The block generates the serial clock itself from the system clock through a programmable divider, and it drives a frame marker beside the data. The length of each word, the bit order, the idle level of the serial clock, and the frame marker's enable, length and polarity are all chosen at run time. A sampled status input, with its own polarity select, lets the receiver hold off new words.

While words keep arriving, they leave back to back. The first bit of the next word follows the last bit of the previous one with no idle clock between them. When no word is pending, the port parks. The serial clock rests at its inactive level, the data line keeps its last bit, and the frame marker is inactive. The configuration inputs are copied every cycle while the port is idle. They are frozen for as long as a word, or a stream of words, is being sent.

Top module: `sync_ser_tx`

## Requirements
- R1: Each half of a serial clock period lasts `cfg_div+1` system cycles, so a full period lasts `2*(cfg_div+1)` system cycles.
- R2: A word holds `cfg_len+1` bits, taken from the low bits of `in_data`. With `cfg_msb_first=0`, bit 0 is sent first and bit `cfg_len` last. With `cfg_msb_first=1`, the order is reversed.
- R3: With `cfg_clk_inv=0`, the serial clock idles low and the data line changes only while the clock is low, so the data is stable at the rising edge. With `cfg_clk_inv=1`, every level is mirrored: the clock idles high and the receiver samples on the falling edge.
- R4: With `cfg_fs_en=0`, `ser_frame` stays at its inactive level for the whole word.
- R5: In one-bit frame mode (`cfg_fs_en=1`, `cfg_fs_word=0`), the frame is active for exactly the clock period of the first bit of every word.
- R6: In word frame mode (`cfg_fs_word=1`), the frame is active for every bit of a word, and it stays active across words that are streamed back to back.
- R7: With `cfg_fs_inv=0`, an active frame is high. With `cfg_fs_inv=1`, an active frame is low and the inactive level is high.
- R8: If a word is offered when the last bit of the current word ends, `in_ready` is high in that cycle. The next word's first bit then follows one full serial period after the previous bit, with no idle clock between them. While a word is being sent, `in_ready` is high in no other cycle.
- R9: When no word is pending, the serial clock rests at its inactive level, the frame is inactive and `ser_data` keeps the last bit that was sent.
- R10: `status_in`, registered for one cycle and XORed with `cfg_stat_inv`, is the busy indication. While it is 1, no new word is accepted (`in_ready=0`). A word already started is still completed.
- R11: The configuration inputs are sampled every cycle while the port is idle and are frozen while a word is being sent. A change made during a word affects only words that start after the port returns to idle.
- R12: After reset, `in_ready=1` and `ser_clk`, `ser_data` and `ser_frame` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Half-period divider value |
| cfg_len | input | $clog2(MAX_WORD) | Word length minus one |
| cfg_msb_first | input | 1 | 1 sends the most significant bit first |
| cfg_clk_inv | input | 1 | 1 makes the serial clock idle high |
| cfg_fs_en | input | 1 | Frame marker enable |
| cfg_fs_word | input | 1 | 1 makes the frame span the whole word, 0 makes it one bit long |
| cfg_fs_inv | input | 1 | 1 makes the frame active low |
| cfg_stat_inv | input | 1 | 1 inverts the status input |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The word is taken at this clock edge |
| in_data | input | MAX_WORD | Word to send |
| status_in | input | 1 | Receiver status (busy when active) |
| ser_clk | output | 1 | Generated serial clock |
| ser_data | output | 1 | Serial data |
| ser_frame | output | 1 | Frame marker |

## Verification
The hardest case to reach is a stream seam. The last half-period of one word must coincide with a waiting valid word, and this must happen with the shortest divider and with one-bit words, where the end of a word falls only two cycles after its load. The stimulus keeps `in_valid` high across calls and presents each new word at the falling system edge right after the previous word is accepted. The bench measures the gap between sampling edges across each seam. The busy hold-off is reached by raising status before a word is offered, and also by raising it in the middle of a word so that the current word completes and the next one waits.

// File: rtl/sst_pkg.sv
package sst_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } sst_state_e;

  // Pin level from an active flag and a polarity select.
  function automatic logic pin_level(input logic active, input logic invert);
    return active ^ invert;
  endfunction

endpackage

// File: rtl/sst_divider.sv
module sst_divider #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
  parameter int unsigned MAX_WORD = 16,
  localparam int unsigned LEN_W   = $clog2(MAX_WORD)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                advance,
  input  logic [MAX_WORD-1:0] data_in,
  input  logic [LEN_W-1:0]    len,
  input  logic                msb_first,
  output logic                first,
  output logic                last,
  output logic                sdata
);

  logic [MAX_WORD-1:0] word_q;
  logic [LEN_W-1:0]    idx_q;
  logic                sdata_q;
  logic [LEN_W-1:0]    idx_nxt;

  // Position in the word of the idx-th transmitted bit.
  function automatic logic [LEN_W-1:0] pick(input logic [LEN_W-1:0] idx,
                                            input logic [LEN_W-1:0] n_m1,
                                            input logic             rev);
    return rev ? (n_m1 - idx) : idx;
  endfunction

  assign idx_nxt = idx_q + 1'b1;
  assign first   = (idx_q == '0);
  assign last    = (idx_q == len);
  assign sdata   = sdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      idx_q   <= '0;
      sdata_q <= 1'b0;
    end else if (load) begin
      word_q  <= data_in;
      idx_q   <= '0;
      sdata_q <= data_in[pick('0, len, msb_first)];
    end else if (advance) begin
      idx_q   <= idx_nxt;
      sdata_q <= word_q[pick(idx_nxt, len, msb_first)];
    end
  end

endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
  import sst_pkg::*;
#(
  parameter int unsigned MAX_WORD = 16,
  parameter int unsigned DIV_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DIV_W-1:0]            cfg_div,
  input  logic [$clog2(MAX_WORD)-1:0] cfg_len,
  input  logic                        cfg_msb_first,
  input  logic                        cfg_clk_inv,
  input  logic                        cfg_fs_en,
  input  logic                        cfg_fs_word,
  input  logic                        cfg_fs_inv,
  input  logic                        cfg_stat_inv,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [MAX_WORD-1:0]         in_data,
  input  logic                        status_in,
  output logic                        ser_clk,
  output logic                        ser_data,
  output logic                        ser_frame
);

  localparam int unsigned LEN_W = $clog2(MAX_WORD);

  sst_state_e       state_q;
  logic             ph_q;
  logic             status_q;

  // Configuration copy: follows the inputs while idle, frozen while shifting.
  logic [DIV_W-1:0] div_q;
  logic [LEN_W-1:0] len_q;
  logic             msb_q, cinv_q, fen_q, fword_q, finv_q, sinv_q;

  // Named internal events.
  logic             shifting, half_tick, bit_end, bit_adv, word_end;
  logic             word_load, busy, first_bit, last_bit;
  logic [LEN_W-1:0] eff_len;
  logic             eff_msb;

  assign shifting  = (state_q == ST_SHIFT);
  assign bit_end   = half_tick & ph_q;
  assign word_end  = bit_end & last_bit;
  assign bit_adv   = bit_end & ~last_bit;
  assign busy      = status_q ^ sinv_q;
  assign in_ready  = ~busy & (~shifting | word_end);
  assign word_load = in_valid & in_ready;
  assign eff_len   = shifting ? len_q : cfg_len;
  assign eff_msb   = shifting ? msb_q : cfg_msb_first;

  sst_divider #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (shifting),
    .div   (div_q),
    .tick  (half_tick)
  );

  sst_shifter #(.MAX_WORD(MAX_WORD)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (word_load),
    .advance   (bit_adv),
    .data_in   (in_data),
    .len       (eff_len),
    .msb_first (eff_msb),
    .first     (first_bit),
    .last      (last_bit),
    .sdata     (ser_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ph_q     <= 1'b0;
      status_q <= 1'b0;
    end else begin
      status_q <= status_in;
      if (word_load) begin
        state_q <= ST_SHIFT;
        ph_q    <= 1'b0;
      end else begin
        if (word_end)  state_q <= ST_IDLE;
        if (half_tick) ph_q    <= ~ph_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      len_q   <= '0;
      msb_q   <= 1'b0;
      cinv_q  <= 1'b0;
      fen_q   <= 1'b0;
      fword_q <= 1'b0;
      finv_q  <= 1'b0;
      sinv_q  <= 1'b0;
    end else if (!shifting) begin
      div_q   <= cfg_div;
      len_q   <= cfg_len;
      msb_q   <= cfg_msb_first;
      cinv_q  <= cfg_clk_inv;
      fen_q   <= cfg_fs_en;
      fword_q <= cfg_fs_word;
      finv_q  <= cfg_fs_inv;
      sinv_q  <= cfg_stat_inv;
    end
  end

  assign ser_clk   = pin_level(shifting & ph_q, cinv_q);
  assign ser_frame = pin_level(shifting & fen_q & (fword_q | first_bit), finv_q);

endmodule

// File: rtl/sst_tx_chk.sv
module sst_tx_chk #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned LEN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shifting,
  input logic             half_tick,
  input logic             word_load,
  input logic             bit_adv,
  input logic             word_end,
  input logic             busy,
  input logic             in_ready,
  input logic             ser_data,
  input logic             ser_frame,
  input logic             first_bit,
  input logic [DIV_W-1:0] div_q,
  input logic [LEN_W-1:0] len_q,
  input logic             msb_q,
  input logic             cinv_q,
  input logic             fen_q,
  input logic             fword_q,
  input logic             finv_q
);

  logic [DIV_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else if (half_tick || !shifting) gap_q <= '0;
    else gap_q <= gap_q + 1'b1;
  end

  // R1
  half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shifting && half_tick) |-> (gap_q == div_q));

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_load || bit_adv) |=> $stable(ser_data));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shifting && $past(!shifting)) |-> $stable(ser_data));

  // R4
  frame_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fen_q |-> (ser_frame == finv_q));

  // R5
  bit_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shifting && !first_bit && !fword_q) |-> (ser_frame == finv_q));

  // R8
  stream_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shifting && in_ready) |-> word_end);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  // R11
  cfg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shifting && $past(shifting)) |->
      $stable({div_q, len_q, msb_q, cinv_q, fen_q, fword_q, finv_q}));

endmodule

bind sync_ser_tx sst_tx_chk #(.DIV_W(DIV_W), .LEN_W($clog2(MAX_WORD))) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .shifting  (shifting),
  .half_tick (half_tick),
  .word_load (word_load),
  .bit_adv   (bit_adv),
  .word_end  (word_end),
  .busy      (busy),
  .in_ready  (in_ready),
  .ser_data  (ser_data),
  .ser_frame (ser_frame),
  .first_bit (first_bit),
  .div_q     (div_q),
  .len_q     (len_q),
  .msb_q     (msb_q),
  .cinv_q    (cinv_q),
  .fen_q     (fen_q),
  .fword_q   (fword_q),
  .finv_q    (finv_q)
);

// File: tb/sync_ser_tx_bench.sv
module sync_ser_tx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_div = 8'd1;
  logic [3:0]  cfg_len = 4'd7;
  logic        cfg_msb_first = 1'b0;
  logic        cfg_clk_inv = 1'b0;
  logic        cfg_fs_en = 1'b1;
  logic        cfg_fs_word = 1'b0;
  logic        cfg_fs_inv = 1'b0;
  logic        cfg_stat_inv = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        status_in = 1'b0;
  logic        ser_clk, ser_data, ser_frame;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_ser_tx u_sync_ser_tx (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len(cfg_len),
    .cfg_msb_first(cfg_msb_first), .cfg_clk_inv(cfg_clk_inv),
    .cfg_fs_en(cfg_fs_en), .cfg_fs_word(cfg_fs_word), .cfg_fs_inv(cfg_fs_inv),
    .cfg_stat_inv(cfg_stat_inv), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .status_in(status_in), .ser_clk(ser_clk),
    .ser_data(ser_data), .ser_frame(ser_frame)
  );

  typedef struct {
    logic d;
    logic f;
    int   gap;
    int   gtag;
    int   ftag;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    errors = 0;
  logic  last_bit = 1'b0;

  task automatic check(input bit ok, input int rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // Driver: call at a falling edge. Pushes the expected bits, then holds the
  // word until it is taken.
  task automatic send_word(input logic [15:0] w, input bit stream, input bit keep);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    for (int i = 0; i <= int'(cfg_len); i++) begin
      item_t it;
      int p;
      p = cfg_msb_first ? (int'(cfg_len) - i) : i;
      it.d = w[p];
      if (!cfg_fs_en) begin
        it.f = cfg_fs_inv;    it.ftag = 4;
      end else begin
        it.f = ((cfg_fs_word || i == 0) ? 1'b1 : 1'b0) ^ cfg_fs_inv;
        it.ftag = cfg_fs_inv ? 7 : (cfg_fs_word ? 6 : 5);
      end
      if (i > 0) begin
        it.gap = 2 * (int'(cfg_div) + 1); it.gtag = 1;
      end else if (stream) begin
        it.gap = 2 * (int'(cfg_div) + 1); it.gtag = 8;
      end else begin
        it.gap = 0; it.gtag = 0;
      end
      exp_q.push_back(it);
      last_bit = it.d;
    end
    @(negedge clk);
    if (!keep) in_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (exp_q.size() != 0 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(exp_q.size() == 0, 2, "bits still expected", exp_q.size(), 0);
    exp_q.delete();
    repeat (2 * (int'(cfg_div) + 1) + 4) @(negedge clk);
  endtask

  task automatic idle_check();
    check(ser_clk == cfg_clk_inv, 9, "idle clock level", ser_clk, cfg_clk_inv);
    check(ser_frame == cfg_fs_inv, 9, "idle frame level", ser_frame, cfg_fs_inv);
    check(ser_data == last_bit, 9, "idle data hold", ser_data, last_bit);
  endtask

  // Monitor: pops one item per sampling edge of the serial clock.
  logic prev_clk = 1'b0;
  logic prev_data = 1'b0;
  int   since = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      since = since + 1;
      if (ser_clk != prev_clk && ser_clk == !cfg_clk_inv) begin
        if (exp_q.size() == 0) begin
          check(1'b0, 10, "unexpected bit sent", 1, 0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check(ser_data == it.d, 2, "data bit", ser_data, it.d);
          check(ser_frame == it.f, it.ftag, "frame level", ser_frame, it.f);
          check(ser_data == prev_data, 3, "data moved at sampling edge", ser_data, prev_data);
          if (it.gap != 0) check(since == it.gap, it.gtag, "bit spacing", since, it.gap);
        end
        since = 0;
      end
    end
    prev_clk  = ser_clk;
    prev_data = ser_data;
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(in_ready == 1'b1, 12, "ready after reset", in_ready, 1);
    check(ser_clk == 1'b0, 12, "clock after reset", ser_clk, 0);
    check(ser_data == 1'b0, 12, "data after reset", ser_data, 0);
    check(ser_frame == 1'b0, 12, "frame after reset", ser_frame, 0);

    // R2 R5: single word, LSB first, one-bit frame
    send_word(16'h00A5, 1'b0, 1'b0);
    wait_done();
    idle_check();  // R9

    // R6 R8: MSB first, word frame, fastest clock, three streamed words
    cfg_div = 8'd0; cfg_msb_first = 1'b1; cfg_fs_word = 1'b1;
    repeat (2) @(negedge clk);
    send_word(16'h003C, 1'b0, 1'b1);
    send_word(16'h0081, 1'b1, 1'b1);
    send_word(16'h007E, 1'b1, 1'b0);
    wait_done();
    idle_check();

    // R4 R7: frame disabled with inverted polarity
    cfg_div = 8'd2; cfg_msb_first = 1'b0; cfg_fs_en = 1'b0; cfg_fs_inv = 1'b1;
    repeat (2) @(negedge clk);
    send_word(16'h005A, 1'b0, 1'b0);
    wait_done();
    idle_check();

    // R3 R7: inverted clock, active-low one-bit frame, 12-bit words streamed
    cfg_fs_en = 1'b1; cfg_fs_word = 1'b0; cfg_clk_inv = 1'b1; cfg_len = 4'd11;
    repeat (2) @(negedge clk);
    check(ser_clk == 1'b1, 3, "inverted idle clock", ser_clk, 1);
    send_word(16'h0ABC, 1'b0, 1'b1);
    send_word(16'h0123, 1'b1, 1'b0);
    wait_done();
    idle_check();

    // R10: busy holds off a new word
    cfg_clk_inv = 1'b0; cfg_len = 4'd7; cfg_div = 8'd1; cfg_fs_inv = 1'b0;
    repeat (2) @(negedge clk);
    status_in = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0, 10, "ready while busy", in_ready, 0);
    in_valid = 1'b1; in_data = 16'h0099;
    repeat (20) @(negedge clk);
    check(in_ready == 1'b0, 10, "ready held while busy", in_ready, 0);
    check(ser_clk == 1'b0, 10, "no clock while busy", ser_clk, 0);
    status_in = 1'b0;
    send_word(16'h0099, 1'b0, 1'b0);
    wait_done();
    // R10: busy raised mid-word lets the word finish, next waits
    send_word(16'h00F0, 1'b0, 1'b1);
    status_in = 1'b1;
    in_data = 16'h0011;
    wait_done();
    check(in_ready == 1'b0, 10, "next word held after busy", in_ready, 0);
    in_valid = 1'b0;
    status_in = 1'b0;
    // R10: inverted status polarity
    cfg_stat_inv = 1'b1; status_in = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, 10, "ready with inverted status", in_ready, 1);
    cfg_stat_inv = 1'b0; status_in = 1'b0;
    repeat (3) @(negedge clk);

    // R11: a configuration change during a word is ignored for that word
    send_word(16'h00C3, 1'b0, 1'b0);
    cfg_msb_first = 1'b1; cfg_len = 4'd3;
    wait_done();
    send_word(16'h00C3, 1'b0, 1'b0);   // now 4 bits, MSB first
    wait_done();
    idle_check();

    // R8 R2: one-bit words streamed at the fastest clock
    cfg_len = 4'd0; cfg_div = 8'd0; cfg_fs_word = 1'b0;
    repeat (2) @(negedge clk);
    send_word(16'h0001, 1'b0, 1'b1);
    send_word(16'h0000, 1'b1, 1'b1);
    send_word(16'h0001, 1'b1, 1'b0);
    wait_done();
    idle_check();

    finish_run();
  end

endmodule